// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives host software a path into a 32-bit internal register bus through a small 64-bit CSR window. Software writes one control word that holds an opcode, a 13-bit register address and 32 bits of write data. The bridge turns that word into exactly one transaction on a downstream request/acknowledge bus. When the acknowledge returns, the bridge sets a completion flag in a status word and, for reads, stores the returned data beside the flag. Software then polls that flag.

A third, read-only word describes the serial-peripheral master that sits behind the window. It reports the shift order, word width, chip-select count, clock polarity, clock phase and a 16-bit peripheral identifier. All of these are set by elaboration parameters, and the word can be removed by a parameter. Only one transaction can be outstanding at a time. The downstream path adds one register stage in each direction, so a transaction that is acknowledged at once is complete before the host's next poll.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, dn_req is 0 and the status word at offset 0x18 reads as all zeros.
- R2: A write of the control word at offset 0x10 with opcode 1 (read) in bits 63:62 raises dn_req on the next clock edge, with dn_we 0, dn_addr equal to control bits 44:32 and dn_wdata 0.
- R3: A control write with opcode 2 (write) raises dn_req on the next edge, with dn_we 1, dn_addr equal to bits 44:32 and dn_wdata equal to bits 31:0.
- R4: dn_req and its address, direction and data stay constant until dn_ack is sampled high. dn_req falls on that same edge. An acknowledge that arrives while dn_req is low changes nothing.
- R5: On the edge where dn_ack is sampled with dn_req high, status bit 32 becomes 1. Status bits 31:0 take dn_rdata for a read and 0 for a write. All other status bits read 0.
- R6: Launching a read or write clears status bit 32 and status bits 31:0 on the launch edge, so a stale completion is never visible while the new transaction is pending.
- R7: Opcode 0 (no-op) and the unused opcode 3 start no transaction and leave the status word unchanged.
- R8: A control write that arrives while dn_req is high is dropped. The transaction in flight keeps its fields, and no second transaction follows its acknowledge.
- R9: With the parameter word enabled, offset 0x08 reads bit 1 = shift order (1 = least significant bit first), bits 7:2 = word width, bits 13:8 = chip-select count, bit 14 = clock polarity, bit 15 = clock phase and bits 47:32 = peripheral ID. All other bits are 0. With the word disabled, offset 0x08 reads 0.
- R10: Offset 0x10 and every offset other than 0x08 and 0x18 read as 0. Writes to any offset other than 0x10, including 0x08 and 0x18, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Host write strobe, one cycle per write |
| csr_addr | input | CSR_AW | Host byte offset for both reads and writes |
| csr_wdata | input | 64 | Host write data |
| csr_rdata | output | 64 | Read data for csr_addr (combinational) |
| dn_req | output | 1 | Downstream request, held until acknowledged |
| dn_we | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | 13 | Downstream register byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge, one cycle |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
On every cycle, the assertions check the request handshake. They cover request rise and the cleared flag after a launch, stable request fields until the acknowledge, the flag setting after the acknowledge, no launch while busy, and no effect from no-ops or stray acknowledges. The bench's scenarios show the rest. These are the exact placement of the opcode, address and data fields, the read data captured into the status word, the parameter word layout in both variants, and the zero reads and dropped writes at undefined offsets.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  parameter int DATA_W    = 32;
  parameter int ADDR_W    = 13;
  parameter int WORD_W    = 64;
  parameter int ADDR_LSB  = 32;
  parameter int CMD_LSB   = 62;
  parameter int VALID_BIT = 32;

  parameter int OFS_PARAM  = 8'h08;
  parameter int OFS_CTRL   = 8'h10;
  parameter int OFS_STATUS = 8'h18;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_SPARE = 2'd3
  } ibr_op_e;

  typedef struct packed {
    logic              is_write;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ibr_txn_t;

  function automatic ibr_op_e ctrl_op(input logic [WORD_W-1:0] w);
    return ibr_op_e'(w[CMD_LSB +: 2]);
  endfunction

  function automatic logic [ADDR_W-1:0] ctrl_addr(input logic [WORD_W-1:0] w);
    return w[ADDR_LSB +: ADDR_W];
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_data(input logic [WORD_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  function automatic logic op_starts_txn(input ibr_op_e op);
    return (op == OP_READ) || (op == OP_WRITE);
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic valid,
                                                    input logic [DATA_W-1:0] data);
    logic [WORD_W-1:0] w;
    w = '0;
    w[DATA_W-1:0] = data;
    w[VALID_BIT]  = valid;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] param_word(input logic lsb_first,
                                                   input logic [5:0] word_bits,
                                                   input logic [5:0] cs_count,
                                                   input logic pol,
                                                   input logic pha,
                                                   input logic [15:0] periph_id);
    logic [WORD_W-1:0] w;
    w = '0;
    w[1]     = lsb_first;
    w[7:2]   = word_bits;
    w[13:8]  = cs_count;
    w[14]    = pol;
    w[15]    = pha;
    w[47:32] = periph_id;
    return w;
  endfunction

endpackage

// File: rtl/ibr_cmd_decode.sv
module ibr_cmd_decode
  import ibr_pkg::*;
#(
  parameter int CSR_AW = 5
) (
  input  logic              csr_wr,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  input  logic              busy,
  output logic              launch,
  output logic              idle_op_seen,
  output logic              drop_busy,
  output ibr_txn_t          txn
);

  logic    ctrl_hit;
  ibr_op_e op;
  logic    unused_ctrl_bits;

  assign ctrl_hit = csr_wr && (csr_addr == CSR_AW'(OFS_CTRL));
  assign op       = ctrl_op(csr_wdata);

  assign unused_ctrl_bits = ^csr_wdata[CMD_LSB-1:ADDR_LSB+ADDR_W];

  always_comb begin
    launch       = 1'b0;
    idle_op_seen = 1'b0;
    drop_busy    = 1'b0;
    if (ctrl_hit) begin
      if (!op_starts_txn(op)) begin
        idle_op_seen = 1'b1;
      end else if (busy) begin
        drop_busy = 1'b1;
      end else begin
        launch = 1'b1;
      end
    end
  end

  always_comb begin
    txn.is_write = (op == OP_WRITE);
    txn.addr     = ctrl_addr(csr_wdata);
    txn.data     = (op == OP_WRITE) ? ctrl_data(csr_wdata) : '0;
  end

endmodule

// File: rtl/ibr_txn_engine.sv
module ibr_txn_engine
  import ibr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  ibr_txn_t          txn,
  input  logic              dn_ack,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic              dn_req,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              stat_valid,
  output logic [DATA_W-1:0] stat_data,
  output logic              done
);

  assign done = dn_req && dn_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_req     <= 1'b0;
      dn_we      <= 1'b0;
      dn_addr    <= '0;
      dn_wdata   <= '0;
      stat_valid <= 1'b0;
      stat_data  <= '0;
    end else if (launch) begin
      dn_req     <= 1'b1;
      dn_we      <= txn.is_write;
      dn_addr    <= txn.addr;
      dn_wdata   <= txn.data;
      stat_valid <= 1'b0;
      stat_data  <= '0;
    end else if (done) begin
      dn_req     <= 1'b0;
      stat_valid <= 1'b1;
      stat_data  <= dn_we ? '0 : dn_rdata;
    end
  end

endmodule

// File: rtl/ibr_param_reg.sv
module ibr_param_reg
  import ibr_pkg::*;
#(
  parameter bit       PARAM_EN  = 1'b1,
  parameter bit       SHIFT_LSB = 1'b0,
  parameter int       WORD_BITS = 32,
  parameter int       CS_COUNT  = 1,
  parameter bit       CLK_POL   = 1'b0,
  parameter bit       CLK_PHA   = 1'b0,
  parameter bit [15:0] PERIPH_ID = 16'h0000
) (
  output logic [WORD_W-1:0] param_q
);

  generate
    if (PARAM_EN) begin : g_param
      assign param_q = param_word(SHIFT_LSB, 6'(WORD_BITS), 6'(CS_COUNT),
                                  CLK_POL, CLK_PHA, PERIPH_ID);
    end else begin : g_no_param
      assign param_q = '0;
    end
  endgenerate

endmodule

// File: rtl/ibr_csr_read.sv
module ibr_csr_read
  import ibr_pkg::*;
#(
  parameter int CSR_AW = 5
) (
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [WORD_W-1:0] param_q,
  input  logic [WORD_W-1:0] status_q,
  output logic [WORD_W-1:0] csr_rdata
);

  always_comb begin
    if (csr_addr == CSR_AW'(OFS_PARAM)) begin
      csr_rdata = param_q;
    end else if (csr_addr == CSR_AW'(OFS_STATUS)) begin
      csr_rdata = status_q;
    end else begin
      csr_rdata = '0;
    end
  end

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ibr_pkg::*;
#(
  parameter int        CSR_AW    = 5,
  parameter bit        PARAM_EN  = 1'b1,
  parameter bit        SHIFT_LSB = 1'b0,
  parameter int        WORD_BITS = 32,
  parameter int        CS_COUNT  = 1,
  parameter bit        CLK_POL   = 1'b0,
  parameter bit        CLK_PHA   = 1'b0,
  parameter bit [15:0] PERIPH_ID = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  output logic [63:0]       csr_rdata,
  output logic              dn_req,
  output logic              dn_we,
  output logic [12:0]       dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic              dn_ack,
  input  logic [31:0]       dn_rdata
);

  logic              launch_fire;
  logic              idle_op_seen;
  logic              drop_busy;
  logic              txn_done;
  ibr_txn_t          txn_next;
  logic              stat_valid;
  logic [DATA_W-1:0] stat_data;
  logic [WORD_W-1:0] status_q;
  logic [WORD_W-1:0] param_q;

  ibr_cmd_decode #(.CSR_AW(CSR_AW)) u_decode (
    .csr_wr       (csr_wr),
    .csr_addr     (csr_addr),
    .csr_wdata    (csr_wdata),
    .busy         (dn_req),
    .launch       (launch_fire),
    .idle_op_seen (idle_op_seen),
    .drop_busy    (drop_busy),
    .txn          (txn_next)
  );

  ibr_txn_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch_fire),
    .txn        (txn_next),
    .dn_ack     (dn_ack),
    .dn_rdata   (dn_rdata),
    .dn_req     (dn_req),
    .dn_we      (dn_we),
    .dn_addr    (dn_addr),
    .dn_wdata   (dn_wdata),
    .stat_valid (stat_valid),
    .stat_data  (stat_data),
    .done       (txn_done)
  );

  ibr_param_reg #(
    .PARAM_EN  (PARAM_EN),
    .SHIFT_LSB (SHIFT_LSB),
    .WORD_BITS (WORD_BITS),
    .CS_COUNT  (CS_COUNT),
    .CLK_POL   (CLK_POL),
    .CLK_PHA   (CLK_PHA),
    .PERIPH_ID (PERIPH_ID)
  ) u_param (
    .param_q (param_q)
  );

  assign status_q = status_word(stat_valid, stat_data);

  ibr_csr_read #(.CSR_AW(CSR_AW)) u_rd (
    .csr_addr  (csr_addr),
    .param_q   (param_q),
    .status_q  (status_q),
    .csr_rdata (csr_rdata)
  );

endmodule

// File: rtl/ibr_checker.sv
module ibr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        launch,
  input logic        idle_op_seen,
  input logic        drop_busy,
  input logic        done,
  input logic        dn_req,
  input logic        dn_we,
  input logic [12:0] dn_addr,
  input logic [31:0] dn_wdata,
  input logic        dn_ack,
  input logic        stat_valid,
  input logic [31:0] stat_data
);

  AST_LAUNCH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> dn_req && !stat_valid && (stat_data == 32'd0)); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> dn_req && $stable(dn_we) && $stable(dn_addr) && $stable(dn_wdata)); // R4

  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !dn_req && stat_valid); // R5

  AST_WR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && dn_we |=> stat_data == 32'd0); // R5

  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> !launch); // R8

  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_busy && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_we)); // R8

  AST_IDLE_OP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_op_seen && !dn_req |=> !dn_req && $stable(stat_valid) && $stable(stat_data)); // R7

  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_req && dn_ack && !launch |=> !dn_req && $stable(stat_valid) && $stable(stat_data)); // R4

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({launch, idle_op_seen, drop_busy})); // R7

endmodule

bind ind_reg_bridge ibr_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .launch       (launch_fire),
  .idle_op_seen (idle_op_seen),
  .drop_busy    (drop_busy),
  .done         (txn_done),
  .dn_req       (dn_req),
  .dn_we        (dn_we),
  .dn_addr      (dn_addr),
  .dn_wdata     (dn_wdata),
  .dn_ack       (dn_ack),
  .stat_valid   (stat_valid),
  .stat_data    (stat_data)
);

// File: tb/ind_reg_bridge_test.sv
module ind_reg_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [4:0]  csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        dn_req, dn_we;
  logic [12:0] dn_addr;
  logic [31:0] dn_wdata;
  logic        dn_ack = 1'b0;
  logic [31:0] dn_rdata = '0;
  logic [63:0] np_rdata;
  logic        np_req, np_we;
  logic [12:0] np_addr;
  logic [31:0] np_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ind_reg_bridge #(
    .CSR_AW(5), .PARAM_EN(1'b1), .SHIFT_LSB(1'b1), .WORD_BITS(24),
    .CS_COUNT(3), .CLK_POL(1'b1), .CLK_PHA(1'b0), .PERIPH_ID(16'hB3C1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dn_req(dn_req),
    .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata)
  );

  ind_reg_bridge #(.CSR_AW(5), .PARAM_EN(1'b0)) uut_np (
    .clk(clk), .rst_n(rst_n), .csr_wr(1'b0), .csr_addr(csr_addr),
    .csr_wdata(64'd0), .csr_rdata(np_rdata), .dn_req(np_req),
    .dn_we(np_we), .dn_addr(np_addr), .dn_wdata(np_wdata),
    .dn_ack(1'b0), .dn_rdata(32'd0)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [12:0] addr;
    logic [31:0] wdata;
    logic [3:0]  wait_cyc;
    logic [31:0] resp;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 13'h0004, 32'h00000000, 4'd0, 32'hDEADBEEF},
    '{2'd2, 13'h1FFC, 32'h12345678, 4'd2, 32'hAAAA5555},
    '{2'd0, 13'h0010, 32'hCAFEF00D, 4'd0, 32'h00000000},
    '{2'd1, 13'h1000, 32'h00000000, 4'd5, 32'h0F0F00FF},
    '{2'd3, 13'h0020, 32'h11111111, 4'd0, 32'h00000000},
    '{2'd2, 13'h0000, 32'hFFFFFFFF, 4'd1, 32'h76543210},
    '{2'd1, 13'h00A8, 32'h00000000, 4'd3, 32'h80000001}
  };

  function automatic logic [63:0] stat_exp(input logic v, input logic [31:0] d);
    return {31'd0, v, d};
  endfunction

  function automatic logic [63:0] ctrl_word(input logic [1:0] op, input logic [12:0] a,
                                            input logic [31:0] d);
    return {op, 17'd0, a, d};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic csr_read(input logic [4:0] a, output logic [63:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic ack_pulse(input logic [31:0] r);
    dn_ack = 1'b1; dn_rdata = r;
    @(negedge clk);
    dn_ack = 1'b0; dn_rdata = '0;
  endtask

  logic [63:0] rd;
  logic [63:0] exp_stat;
  logic [63:0] exp_param;

  initial begin
    exp_param = (64'd1 << 1) | (64'd24 << 2) | (64'd3 << 8) | (64'd1 << 14) | (64'hB3C1 << 32);
    exp_stat  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 req", {63'd0, dn_req}, 64'd0);
    csr_read(5'h18, rd); check("R1 status", rd, 64'd0);
    // R9 parameter word, both variants
    csr_read(5'h08, rd); check("R9 param", rd, exp_param);
    check("R9 param disabled", np_rdata, 64'd0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      csr_write(5'h10, ctrl_word(v.op, v.addr, v.wdata));
      if (v.op == 2'd1 || v.op == 2'd2) begin
        check(v.op == 2'd1 ? "R2 req" : "R3 req", {63'd0, dn_req}, 64'd1);
        check(v.op == 2'd1 ? "R2 we" : "R3 we", {63'd0, dn_we}, {63'd0, v.op == 2'd2});
        check(v.op == 2'd1 ? "R2 addr" : "R3 addr", {51'd0, dn_addr}, {51'd0, v.addr});
        check(v.op == 2'd1 ? "R2 wdata" : "R3 wdata", {32'd0, dn_wdata},
              {32'd0, (v.op == 2'd2) ? v.wdata : 32'd0});
        csr_read(5'h18, rd); check("R6 cleared", rd, 64'd0);
        for (int w = 0; w < int'(v.wait_cyc); w++) begin
          @(negedge clk);
          check("R4 held", {50'd0, dn_req, dn_addr}, {50'd0, 1'b1, v.addr});
        end
        ack_pulse(v.resp);
        check("R4 drop", {63'd0, dn_req}, 64'd0);
        exp_stat = stat_exp(1'b1, (v.op == 2'd1) ? v.resp : 32'd0);
        csr_read(5'h18, rd); check("R5 status", rd, exp_stat);
      end else begin
        check("R7 no txn", {63'd0, dn_req}, 64'd0);
        csr_read(5'h18, rd); check("R7 status kept", rd, exp_stat);
      end
    end

    // R8 command while busy is dropped
    csr_write(5'h10, ctrl_word(2'd1, 13'h0020, 32'd0));
    csr_write(5'h10, ctrl_word(2'd2, 13'h0040, 32'h00000055));
    check("R8 fields kept", {49'd0, dn_req, dn_we, dn_addr}, {49'd0, 1'b1, 1'b0, 13'h0020});
    ack_pulse(32'h13579BDF);
    check("R8 drop", {63'd0, dn_req}, 64'd0);
    @(negedge clk);
    check("R8 no second txn", {63'd0, dn_req}, 64'd0);
    exp_stat = stat_exp(1'b1, 32'h13579BDF);
    csr_read(5'h18, rd); check("R8 status", rd, exp_stat);

    // R4 stray acknowledge while idle
    ack_pulse(32'hFFFF0000);
    csr_read(5'h18, rd); check("R4 stray ack", rd, exp_stat);
    check("R4 stray req", {63'd0, dn_req}, 64'd0);

    // R10 undefined / read-only offsets
    csr_write(5'h18, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_read(5'h18, rd); check("R10 status write", rd, exp_stat);
    csr_write(5'h08, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_read(5'h08, rd); check("R10 param write", rd, exp_param);
    csr_write(5'h00, ctrl_word(2'd1, 13'h0100, 32'd0));
    check("R10 stray launch", {63'd0, dn_req}, 64'd0);
    csr_read(5'h00, rd); check("R10 read 0x00", rd, 64'd0);
    csr_read(5'h10, rd); check("R10 read ctrl", rd, 64'd0);
    csr_read(5'h1C, rd); check("R10 read 0x1C", rd, 64'd0);
    csr_read(5'h0C, rd); check("R10 read 0x0C", rd, 64'd0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule